// File: doc/BRIEF.md
# Bit-Skewed Pipelined Adder/Subtractor

This block adds or subtracts two W-bit two's-complement words with a carry chain that is cut by a register after every bit position. The full-adder for bit k is evaluated in pipeline level k+1, so the carry advances one bit per clock. Operand bits wait in their own register chains until their level is reached. Finished sum bits are held in further register chains until the last bit is done, so the whole result leaves on one cycle. A new operation can enter every clock, and each operation carries its own mode bits.

Subtraction uses the same adder cells. The subtrahend is inverted bit by bit and the first carry-in is forced to 1. When the nest input is set, a third operand C is added to the first result. This second ripple runs one level behind the first, so the pipeline only grows by a single level and never has to wait for the first result to be complete. A valid flag travels through the levels beside the data. There is no back-pressure.

Top module: `skew_ripple_addsub`

## Requirements
- R1: While reset is asserted, and after it is released until a valid input has passed through the pipeline, valid_o is 0.
- R2: With sub_i=0 and nest_i=0, an operation sampled at clock edge n gives sum_o = (A+B) mod 2^W, with carry_o equal to the carry out of bit W-1. The result appears after edge n+W, which is W+1 cycles of latency.
- R3: With sub_i=1, sum_o = (A-B) mod 2^W. Here carry_o=1 exactly when A >= B as unsigned values (no borrow).
- R4: With nest_i=1, sum_o = (first result + C) mod 2^W, where the first result is A+B or A-B as selected by sub_i. carry2_o is the carry out of this second addition, and carry_o still reports the carry of the first.
- R5: With nest_i=0, the value of C has no effect: sum_o equals the first result and carry2_o=0.
- R6: A new operation is accepted on every clock. Each result follows the sub_i and nest_i sampled with its own operands, even when the modes change from one cycle to the next.
- R7: valid_o repeats valid_i exactly W+1 cycles later, gaps included. Cycles with valid_i low produce no valid result.
- R8: The worst-case carry chains complete correctly: all ones plus 1 gives 0 with carry 1, and A-A gives 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on this cycle are valid |
| sub_i | input | 1 | 1: A-B, 0: A+B |
| nest_i | input | 1 | 1: also add C to the first result |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| c_i | input | W | Operand C, used only when nest_i=1 |
| valid_o | output | 1 | Result on this cycle is valid |
| sum_o | output | W | Aligned result word |
| carry_o | output | 1 | Carry out of the A/B addition (no-borrow flag for subtraction) |
| carry2_o | output | 1 | Carry out of the nested C addition, 0 when not nested |

## Verification
Each result is due W+1 clock edges after the edge that samples its operands: W levels for the first ripple and one more for the nested level. The bench drives operands just after a falling edge, so they are captured at the next rising edge. At every falling edge it first compares the outputs against the operation it drove W+1 steps earlier, which it keeps in a history ring, and only then drives the next operands. Operations are streamed back to back, with the modes changing per cycle and with valid gaps. Before each scenario ends, idle cycles are run so that every result of that scenario has been checked by the scenario itself.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  // one-bit full adder: {carry, sum}
  function automatic logic [1:0] fa(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

endpackage

// File: rtl/addsub_ingest.sv
// Level 0: operand conditioning, combinational.
module addsub_ingest #(
  parameter int W = 8
) (
  input  logic         valid_i,
  input  logic         sub_i,
  input  logic         nest_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         vld_o,
  output logic         nest_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] s2_o,
  output logic         cy1_o,
  output logic         cy2_o
);
  always_comb begin
    vld_o  = valid_i;
    nest_o = nest_i;
    a_o    = a_i;
    b_o    = sub_i ? ~b_i : b_i;
    c_o    = nest_i ? c_i : '0;
    s1_o   = '0;
    s2_o   = '0;
    cy1_o  = sub_i;   // +1 completes the two's complement
    cy2_o  = 1'b0;
  end
endmodule

// File: rtl/addsub_stage.sv
// Level LVL: first ripple on bit LVL-1, nested ripple on bit LVL-2.
module addsub_stage
  import addsub_pkg::*;
#(
  parameter int W   = 8,
  parameter int LVL = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic         nest_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] s1_i,
  input  logic [W-1:0] s2_i,
  input  logic         cy1_i,
  input  logic         cy2_i,
  output logic         vld_o,
  output logic         nest_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] s2_o,
  output logic         cy1_o,
  output logic         cy2_o
);
  localparam bit DO1 = (LVL <= W);
  localparam bit DO2 = (LVL >= 2);
  localparam int K   = DO1 ? LVL - 1 : W - 1;
  localparam int J   = DO2 ? LVL - 2 : 0;
  localparam logic [W-1:0] MASK_AB = DO1 ? ~(W'(1) << K) : '1;
  localparam logic [W-1:0] MASK_C  = DO2 ? ~(W'(1) << J) : '1;

  logic [W-1:0] s1_n, s2_n;
  logic         cy1_n, cy2_n;

  always_comb begin
    s1_n  = s1_i;
    s2_n  = s2_i;
    cy1_n = cy1_i;
    cy2_n = cy2_i;
    if (DO1) {cy1_n, s1_n[K]} = fa(a_i[K], b_i[K], cy1_i);
    if (DO2) {cy2_n, s2_n[J]} = fa(s1_i[J], c_i[J], cy2_i);
  end

  // consumed operand bits are dropped, later levels keep only pending ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      nest_o <= 1'b0;
      a_o    <= '0;
      b_o    <= '0;
      c_o    <= '0;
      s1_o   <= '0;
      s2_o   <= '0;
      cy1_o  <= 1'b0;
      cy2_o  <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      nest_o <= nest_i;
      a_o    <= a_i & MASK_AB;
      b_o    <= b_i & MASK_AB;
      c_o    <= c_i & MASK_C;
      s1_o   <= s1_n;
      s2_o   <= s2_n;
      cy1_o  <= cy1_n;
      cy2_o  <= cy2_n;
    end
  end

  // R5: with C forced to zero the nested chain never carries
  a_r5_quiet_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !nest_i) |-> !cy2_i);

endmodule

// File: rtl/skew_ripple_addsub.sv
module skew_ripple_addsub #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sub_i,
  input  logic         nest_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         carry2_o
);
  localparam int LAST = W + 1;   // one level per bit plus the nested tail

  logic         vld_l  [LAST+1];
  logic         nest_l [LAST+1];
  logic [W-1:0] a_l    [LAST+1];
  logic [W-1:0] b_l    [LAST+1];
  logic [W-1:0] c_l    [LAST+1];
  logic [W-1:0] s1_l   [LAST+1];
  logic [W-1:0] s2_l   [LAST+1];
  logic         cy1_l  [LAST+1];
  logic         cy2_l  [LAST+1];

  addsub_ingest #(.W(W)) u_ingest (
    .valid_i (valid_i),
    .sub_i   (sub_i),
    .nest_i  (nest_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .vld_o   (vld_l[0]),
    .nest_o  (nest_l[0]),
    .a_o     (a_l[0]),
    .b_o     (b_l[0]),
    .c_o     (c_l[0]),
    .s1_o    (s1_l[0]),
    .s2_o    (s2_l[0]),
    .cy1_o   (cy1_l[0]),
    .cy2_o   (cy2_l[0])
  );

  for (genvar l = 1; l <= LAST; l++) begin : g_lvl
    addsub_stage #(.W(W), .LVL(l)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_l[l-1]),
      .nest_i (nest_l[l-1]),
      .a_i    (a_l[l-1]),
      .b_i    (b_l[l-1]),
      .c_i    (c_l[l-1]),
      .s1_i   (s1_l[l-1]),
      .s2_i   (s2_l[l-1]),
      .cy1_i  (cy1_l[l-1]),
      .cy2_i  (cy2_l[l-1]),
      .vld_o  (vld_l[l]),
      .nest_o (nest_l[l]),
      .a_o    (a_l[l]),
      .b_o    (b_l[l]),
      .c_o    (c_l[l]),
      .s1_o   (s1_l[l]),
      .s2_o   (s2_l[l]),
      .cy1_o  (cy1_l[l]),
      .cy2_o  (cy2_l[l])
    );
  end

  assign valid_o  = vld_l[LAST];
  assign sum_o    = s2_l[LAST];
  assign carry_o  = cy1_l[LAST];
  assign carry2_o = cy2_l[LAST];

  // R6: every operand bit has been consumed by the time a result leaves
  a_r6_operands_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (a_l[LAST] == '0 && b_l[LAST] == '0 && c_l[LAST] == '0));

  // R5: without nesting the aligned result equals the first ripple
  a_r5_nest_off_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nest_l[LAST]) |-> (sum_o == s1_l[LAST]));

  a_r5_no_carry2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !nest_l[LAST]) |-> !carry2_o);

endmodule

// File: tb/skew_ripple_addsub_test.sv
module skew_ripple_addsub_test;
  localparam int W   = 8;
  localparam int LAT = W + 1;
  localparam int M   = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0, sub_i = 1'b0, nest_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, c_i = '0;
  logic         valid_o, carry_o, carry2_o;
  logic [W-1:0] sum_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic  hv   [64];
  int    hsum [64];
  int    hc1  [64];
  int    hc2  [64];
  string htag [64];

  always #5 clk = ~clk;

  skew_ripple_addsub #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sub_i(sub_i), .nest_i(nest_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .valid_o(valid_o), .sum_o(sum_o), .carry_o(carry_o), .carry2_o(carry2_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // one cycle: check result due now, then drive the next operands
  task automatic step(input logic v, input logic s, input logic n,
                      input int a, input int b, input int c, input string tag);
    int p, idx, first, cy1, second;
    @(negedge clk);
    p = cyc - LAT;
    if (p < 0) chk("R1 valid", int'(valid_o), 0);
    else begin
      idx = p % 64;
      chk("R7 valid", int'(valid_o), int'(hv[idx]));
      if (hv[idx] && valid_o) begin
        chk({htag[idx], " sum"}, int'(sum_o), hsum[idx]);
        chk({htag[idx], " carry"}, int'(carry_o), hc1[idx]);
        chk({htag[idx], " carry2"}, int'(carry2_o), hc2[idx]);
      end
    end
    a &= M; b &= M; c &= M;
    first  = s ? (a - b) & M : (a + b) & M;
    cy1    = s ? int'(a >= b) : int'((a + b) > M);
    second = first + (n ? c : 0);
    idx = cyc % 64;
    hv[idx] = v; hsum[idx] = second & M; hc1[idx] = cy1;
    hc2[idx] = (second > M) ? 1 : 0; htag[idx] = tag;
    valid_i = v; sub_i = s; nest_i = n;
    a_i = W'(a); b_i = W'(b); c_i = W'(c);
    cyc++;
  endtask

  task automatic flush();
    for (int i = 0; i < LAT; i++) step(1'b0, 1'b0, 1'b0, 0, 0, 0, "idle");
  endtask

  task automatic test_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 valid in reset", int'(valid_o), 0);
    end
    valid_i = 1'b1;   // ignored while in reset
    @(negedge clk);
    chk("R1 valid in reset", int'(valid_o), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    for (int i = 0; i < LAT; i++) step(1'b0, 1'b0, 1'b0, 0, 0, 0, "R1");
  endtask

  task automatic test_add();
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, $urandom, $urandom, $urandom, "R2");
    step(1'b1, 1'b0, 1'b0, 0, 0, 0, "R2");
    step(1'b1, 1'b0, 1'b0, 8'h80, 8'h80, 0, "R2");
    step(1'b1, 1'b0, 1'b0, 8'h55, 8'hAA, 0, "R2");
    flush();
  endtask

  task automatic test_sub();
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, $urandom, $urandom, 0, "R3");
    step(1'b1, 1'b1, 1'b0, 3, 5, 0, "R3");
    step(1'b1, 1'b1, 1'b0, 5, 3, 0, "R3");
    step(1'b1, 1'b1, 1'b0, 0, 1, 0, "R3");
    flush();
  endtask

  task automatic test_nested();
    for (int i = 0; i < 40; i++)
      step(1'b1, 1'(i % 2), 1'b1, $urandom, $urandom, $urandom, "R4");
    step(1'b1, 1'b0, 1'b1, 8'hF0, 8'h0F, 1, "R4");
    step(1'b1, 1'b1, 1'b1, 2, 3, 1, "R4");
    flush();
  endtask

  task automatic test_c_ignored();
    for (int i = 0; i < 30; i++)
      step(1'b1, 1'(i % 3 == 0), 1'b0, $urandom, $urandom, 8'hFF, "R5");
    step(1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'hFF, "R5");
    flush();
  endtask

  task automatic test_mixed();
    for (int i = 0; i < 60; i++)
      step(1'b1, 1'($urandom % 2), 1'($urandom % 2), $urandom, $urandom, $urandom, "R6");
    flush();
  endtask

  task automatic test_gaps();
    for (int i = 0; i < 50; i++)
      step(1'($urandom % 3 != 0), 1'($urandom % 2), 1'($urandom % 2),
           $urandom, $urandom, $urandom, "R7");
    flush();
  endtask

  task automatic test_corners();
    step(1'b1, 1'b0, 1'b0, 8'hFF, 1, 0, "R8");
    step(1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF, 0, "R8");
    step(1'b1, 1'b1, 1'b0, 8'hA5, 8'hA5, 0, "R8");
    step(1'b1, 1'b1, 1'b0, 0, 0, 0, "R8");
    step(1'b1, 1'b0, 1'b1, 8'hFF, 0, 1, "R8");
    step(1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, "R8");
    flush();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) hv[i] = 1'b0;
    test_reset();
    test_add();
    test_sub();
    test_nested();
    test_c_ignored();
    test_mixed();
    test_gaps();
    test_corners();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule